// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a register of `WIDTH` stages (eight by default) that either captures a parallel word or shifts serial data through its stages, with only the last stage visible at the ports, as a true and an inverted bit. A mode input selects the operation. While the mode is low the register keeps copying the parallel word, on every system cycle, whatever the clock inputs do. While the mode is high the register shifts once on each rising edge of the OR of two clock inputs. Because the two clock inputs are interchangeable, either one can be the clock while the other, held high, blocks it.

Everything runs on one fast system clock. The mode input and both clock inputs are slow, asynchronous levels. Each passes through a two-flop synchroniser. The block then looks for rising edges on the OR of the synchronised clocks. The parallel word and the serial input are sampled directly. They are expected to be steady while they are being used.

Top module: `piso_shreg`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `last_q` is 0 and `last_qn` is 1.
- R2: While `shift_mode` is 0, every stage takes the parallel word on every cycle. Stage i takes `par_in[i]`, and stage `WIDTH-1` drives `last_q`, so `last_q` shows `par_in[WIDTH-1]`.
- R3: Edges on `clk_a` or `clk_b` while `shift_mode` is 0 cause no shift. The register still holds the parallel word once shift mode returns.
- R4: With `shift_mode` at 1 and `clk_b` at 0, a rising edge on `clk_a` shifts the register once.
- R5: With `shift_mode` at 1 and `clk_a` at 0, a rising edge on `clk_b` shifts the register once.
- R6: On a shift, stage 0 takes `ser_in` and stage i takes the old value of stage i-1. After k shifts following a load, `last_q` shows `par_in[WIDTH-1-k]`.
- R7: While one clock input is held at 1, edges on the other clock input cause no shift.
- R8: In shift mode with no rising edge on the combined clock, the register holds its contents, even when `ser_in` changes.
- R9: `last_qn` is always the complement of `last_q`.
- R10: Each rising edge of the combined clock gives exactly one shift. With two synchroniser stages, the shift appears on the third system clock edge after the input rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_mode | input | 1 | 1 = shift on the combined clock, 0 = continuous parallel load |
| clk_a | input | 1 | Shift clock input, interchangeable with clk_b |
| clk_b | input | 1 | Shift clock input, interchangeable with clk_a |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | WIDTH | Parallel word; bit i goes to stage i |
| last_q | output | 1 | Value of the last stage |
| last_qn | output | 1 | Complement of the last stage |

## Verification
The hardest case to reach from the ports is the inhibit interaction. Raising the blocking input is itself a rising edge of the combined clock, so it shifts once. Only the edges that follow on the other input are blocked. Lowering the blocking input while the other input is low gives no edge. The stimulus raises one input, pulses the other several times, and then releases the first. It does this in both directions. It then shifts all stages out through `last_q`, which exposes the whole register state, and compares it with a bench queue model.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } mode_e;

  // bit positions inside the synchronised control bus
  localparam int unsigned CTL_CLK_A = 0;
  localparam int unsigned CTL_CLK_B = 1;
  localparam int unsigned CTL_MODE  = 2;
  localparam int unsigned CTL_BITS  = 3;
endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe_q[g] <= RST_VAL;
        else     pipe_q[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe_q[g] <= RST_VAL;
        else     pipe_q[g] <= pipe_q[g-1];
      end
    end
  end

  assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/psr_edge.sv
module psr_edge (
  input  logic clk,
  input  logic rst,
  input  logic clk_a_s,
  input  logic clk_b_s,
  input  logic enable,
  output logic shift_pulse
);
  logic comb_clk;
  logic comb_prev_q;

  assign comb_clk = clk_a_s | clk_b_s;

  // reset to 1 so a clock level held across reset is not an edge
  always_ff @(posedge clk) begin
    if (rst) comb_prev_q <= 1'b1;
    else     comb_prev_q <= comb_clk;
  end

  assign shift_pulse = enable & comb_clk & ~comb_prev_q;
endmodule

// File: rtl/psr_stages.sv
module psr_stages #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] stage_q
);
  logic [WIDTH-1:0] shifted;

  for (genvar i = 0; i < WIDTH; i++) begin : g_link
    if (i == 0) begin : g_head
      assign shifted[i] = ser_in;
    end else begin : g_body
      assign shifted[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        stage_q <= '0;
    else if (load)  stage_q <= par_in;
    else if (shift) stage_q <= shifted;
  end
endmodule

// File: rtl/piso_shreg.sv
module piso_shreg
  import psr_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_mode,
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             ser_in,
  input  logic [WIDTH-1:0] par_in,
  output logic             last_q,
  output logic             last_qn
);
  logic [CTL_BITS-1:0] ctl_raw;
  logic [CTL_BITS-1:0] ctl_sync;
  mode_e               mode_now;
  logic                load_now;
  logic                shift_now;
  logic [WIDTH-1:0]    stage_q;

  assign ctl_raw[CTL_CLK_A] = clk_a;
  assign ctl_raw[CTL_CLK_B] = clk_b;
  assign ctl_raw[CTL_MODE]  = shift_mode;

  psr_sync #(
    .WIDTH  (CTL_BITS),
    .STAGES (SYNC_STAGES),
    .RST_VAL({CTL_BITS{1'b1}})
  ) sync_i (
    .clk (clk),
    .rst (rst),
    .din (ctl_raw),
    .dout(ctl_sync)
  );

  assign mode_now = mode_e'(ctl_sync[CTL_MODE]);
  assign load_now = (mode_now == MODE_LOAD);

  psr_edge edge_i (
    .clk        (clk),
    .rst        (rst),
    .clk_a_s    (ctl_sync[CTL_CLK_A]),
    .clk_b_s    (ctl_sync[CTL_CLK_B]),
    .enable     (mode_now == MODE_SHIFT),
    .shift_pulse(shift_now)
  );

  psr_stages #(.WIDTH(WIDTH)) stages_i (
    .clk    (clk),
    .rst    (rst),
    .load   (load_now),
    .shift  (shift_now),
    .ser_in (ser_in),
    .par_in (par_in),
    .stage_q(stage_q)
  );

  assign last_q  = stage_q[WIDTH-1];
  assign last_qn = ~stage_q[WIDTH-1];
endmodule

// File: rtl/piso_shreg_chk.sv
module piso_shreg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             ser_in,
  input logic [WIDTH-1:0] par_in,
  input logic [WIDTH-1:0] stage,
  input logic             load,
  input logic             shift,
  input logic             last_q,
  input logic             last_qn
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (last_q == 1'b0 && last_qn == 1'b1));

  // R9
  complement_chk: assert property (@(posedge clk) disable iff (rst) last_qn == ~last_q);

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> stage == $past(par_in));

  // R6
  shift_order_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && !load) |=> (stage[0] == $past(ser_in) && stage[WIDTH-1] == $past(stage[WIDTH-2])));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift) |=> $stable(stage));

  // R10
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    shift |=> !shift);
endmodule

bind piso_shreg piso_shreg_chk #(.WIDTH(WIDTH)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .ser_in (ser_in),
  .par_in (par_in),
  .stage  (stage_q),
  .load   (load_now),
  .shift  (shift_now),
  .last_q (last_q),
  .last_qn(last_qn)
);

// File: tb/piso_shreg_tb_top.sv
`timescale 1ns/1ps
module piso_shreg_tb_top;
  localparam int unsigned W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         shift_mode = 1'b1;
  logic         clk_a = 1'b0;
  logic         clk_b = 1'b0;
  logic         ser_in = 1'b0;
  logic [W-1:0] par_in = '0;
  logic         last_q;
  logic         last_qn;

  int  n_checks = 0;
  int  n_bad = 0;
  bit  finished = 1'b0;
  logic [W-1:0] mdl = '0;

  always #2.5 clk = ~clk;

  piso_shreg #(.WIDTH(W), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst(rst), .shift_mode(shift_mode), .clk_a(clk_a), .clk_b(clk_b),
    .ser_in(ser_in), .par_in(par_in), .last_q(last_q), .last_qn(last_qn)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_out(input string req);
    check(req, last_q, mdl[W-1]);
    check("R9", last_qn, ~mdl[W-1]);
  endtask

  // one clean pulse on a chosen clock input, other input low
  task automatic pulse(input bit use_b, input logic sbit, input string req);
    ser_in = sbit;
    if (use_b) clk_b = 1'b1; else clk_a = 1'b1;
    settle();
    mdl = {mdl[W-2:0], sbit};
    if (use_b) clk_b = 1'b0; else clk_a = 1'b0;
    settle();
    check_out(req);
  endtask

  task automatic load_word(input logic [W-1:0] v, input bit toggle);
    par_in = v;
    shift_mode = 1'b0;
    settle();
    check("R2", last_q, v[W-1]);
    if (toggle) begin
      for (int k = 0; k < 3; k++) begin
        clk_a = 1'b1; settle(); clk_a = 1'b0; settle();
        clk_b = 1'b1; settle(); clk_b = 1'b0; settle();
      end
      check("R3", last_q, v[W-1]);
    end
    shift_mode = 1'b1;
    settle();
    mdl = v;
    check_out("R2");
  endtask

  task automatic drain(input string req);
    for (int k = 0; k < W; k++) pulse(k[0], 1'b0, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", last_q, 1'b0);
    check("R1", last_qn, 1'b1);
    rst = 1'b0;
    @(negedge clk);
    check("R1", last_q, 1'b0);
    check("R1", last_qn, 1'b1);
    settle();

    // sweep of parallel words, eight shifts each, alternating clock inputs
    for (int p = 0; p < 16; p++) begin
      logic [W-1:0] v;
      v = W'(p * 8'h5b) ^ 8'hc3;
      load_word(v, p[0]);
      for (int k = 0; k < W; k++) begin
        pulse(k[0], ~v[k], k[0] ? "R5" : "R4");
        check("R6", last_q, (k == W-1) ? ~v[0] : v[W-2-k]);
      end
    end

    // latency: shift lands on the third edge after the rise (R10)
    load_word(8'h80, 1'b0);
    ser_in = 1'b0;
    clk_a = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R10", last_q, 1'b1);
    @(posedge clk);
    @(negedge clk);
    check("R10", last_q, 1'b0);
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R10", last_q, 1'b0);
    clk_a = 1'b0;
    settle();
    mdl = 8'h00;
    check_out("R10");

    // inhibit, clk_b held high (its rise is one shift)
    load_word(8'b1011_0010, 1'b0);
    ser_in = 1'b1;
    clk_b = 1'b1; settle();
    mdl = {mdl[W-2:0], 1'b1};
    for (int k = 0; k < 4; k++) begin
      ser_in = k[0];
      clk_a = 1'b1; settle(); clk_a = 1'b0; settle();
    end
    check_out("R7");
    clk_b = 1'b0; settle();
    check_out("R7");
    for (int k = 0; k < W; k++) begin
      check("R7", last_q, mdl[W-1]);
      pulse(1'b0, 1'b0, "R7");
    end

    // inhibit, clk_a held high
    load_word(8'b0110_1101, 1'b0);
    ser_in = 1'b0;
    clk_a = 1'b1; settle();
    mdl = {mdl[W-2:0], 1'b0};
    for (int k = 0; k < 4; k++) begin
      ser_in = ~k[0];
      clk_b = 1'b1; settle(); clk_b = 1'b0; settle();
    end
    check_out("R7");
    clk_a = 1'b0; settle();
    for (int k = 0; k < W; k++) begin
      check("R7", last_q, mdl[W-1]);
      pulse(1'b1, 1'b1, "R7");
    end

    // hold: serial input toggles with no clock edges
    load_word(8'b1100_1010, 1'b0);
    for (int k = 0; k < 20; k++) begin
      ser_in = k[0];
      @(negedge clk);
    end
    check_out("R8");
    for (int k = 0; k < W; k++) begin
      check("R8", last_q, mdl[W-1]);
      pulse(k[0], 1'b0, "R8");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule